// File: doc/BRIEF.md
# Bit-Test-and-Skip Execution Slice

This block is the slice of an 8-bit accumulator core that executes the two conditional bit-test instructions. Each instruction cycle is split into four clock phases. The core hands the slice the fetched instruction word and a flag saying whether the instruction after it is two words long. The slice forms a data-memory address from the 8-bit file field, either through a fixed access window or through the bank-select register. It reads that register in the second phase and tests one bit of it in the third phase. In the fourth phase it tells the program counter how far to advance.

When the tested bit meets the skip condition, the slice turns the already-fetched next instruction into one no-op cycle. If that instruction has two words, it runs two no-op cycles. The core learns of this through a no-op flag that stays high for each whole squashed cycle. Instructions that are not bit tests pass through: the slice performs no read and advances the PC by one word. No status flag is affected.

Top module: `bitskip_unit`

## Requirements
- R1: After reset the phase is 0, no no-op cycle is pending, and `rf_rd_en`, `pc_step_valid` and `idx_mode` are low.
- R2: `q_phase` counts 0,1,2,3 and wraps, one step per clock. Four clocks form one instruction cycle.
- R3: `instr_word` and `next_two_word` are sampled on the clock edge that ends phase 0. The instruction fields are opcode [15:12], bit index [11:9], bank flag [8] and file address [7:0]. Opcode 4'b1011 is skip-if-clear and 4'b1010 is skip-if-set. For these opcodes `rf_rd_en` is high during phase 1 only. `rf_rdata` is sampled on the edge that ends phase 1.
- R4: With bank flag 1, `rf_addr` is {bsr, file address}.
- R5: With bank flag 0, outside the indexed case, file addresses below 0x60 map to {4'h0, f}. File addresses 0x60 and above map to {4'hF, f}.
- R6: With bank flag 0, `ext_en` high and f at most 0x5F, `idx_mode` is high in phases 1 to 3. In this case `rf_addr` carries the raw offset {4'h0, f}, which outside logic turns into the real address. `idx_mode` is low in every other case.
- R7: Skip-if-clear skips when bit b of the read data is 0.
- R8: Skip-if-set skips when bit b of the read data is 1.
- R9: With no skip, `pc_step_valid` is high in phase 3 with `pc_step` = 1. The next cycle is a normal cycle.
- R10: A skip over a one-word instruction gives `pc_step` = 2, followed by exactly one cycle with `nop_cycle` high.
- R11: A skip over a two-word instruction gives `pc_step` = 3, followed by exactly two cycles with `nop_cycle` high.
- R12: In a no-op cycle `instr_word` is ignored. There is no read and no `pc_step_valid`.
- R13: Any other opcode performs no read and gives `pc_step` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_word | input | 16 | Fetched instruction, sampled at end of phase 0 |
| next_two_word | input | 1 | Following instruction has two words |
| ext_en | input | 1 | Extended instruction set enabled |
| bsr | input | 4 | Bank-select register |
| rf_rdata | input | 8 | Register-file read data |
| q_phase | output | 2 | Current phase within the instruction cycle |
| rf_rd_en | output | 1 | Register-file read strobe |
| rf_addr | output | 12 | Register-file address |
| idx_mode | output | 1 | Indexed literal-offset access in progress |
| nop_cycle | output | 1 | Current cycle is a squashed no-op |
| pc_step_valid | output | 1 | PC advance request |
| pc_step | output | 2 | Words to advance the PC |

## Verification
The read strobe, the address and the indexed flag are due in phase 1, which is the clock after the instruction word is sampled. The PC step is due in phase 3. A squash shows as `nop_cycle` from the phase 0 of the next cycle for one or two full cycles. The bench walks every instruction phase by phase, sampling on the falling edge. At each phase it compares the outputs with values it predicted from the fields it encoded and from its own data function. A check at the wrong phase therefore fails. Junk driven on `instr_word` during squashed cycles shows that those cycles ignore it.

// File: rtl/bitskip_unit.sv
module bitskip_unit #(
  parameter int IW     = 16,
  parameter int DW     = 8,
  parameter int FW     = 8,
  parameter int BW     = 4,
  parameter int LOWWIN = 'h60
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [IW-1:0]        instr_word,
  input  logic                 next_two_word,
  input  logic                 ext_en,
  input  logic [BW-1:0]        bsr,
  input  logic [DW-1:0]        rf_rdata,
  output logic [1:0]           q_phase,
  output logic                 rf_rd_en,
  output logic [BW+FW-1:0]     rf_addr,
  output logic                 idx_mode,
  output logic                 nop_cycle,
  output logic                 pc_step_valid,
  output logic [1:0]           pc_step
);
  localparam int BIW = $clog2(DW);

  logic [IW-1:0]  ir;
  logic           two_q, bit_q, skip_q;
  logic [1:0]     nop_left;

  wire [3:0]     opc    = ir[IW-1 -: 4];
  wire [BIW-1:0] bsel   = ir[FW+1 +: BIW];
  wire           abank  = ir[FW];
  wire [FW-1:0]  faddr  = ir[FW-1:0];
  wire           live   = (nop_left == 2'd0);
  wire           is_tst = (opc[3:1] == 3'b101);
  wire           low_f  = (faddr < FW'(LOWWIN));

  assign nop_cycle     = !live;
  assign rf_rd_en      = live && is_tst && (q_phase == 2'd1);
  assign idx_mode      = live && is_tst && !abank && ext_en && low_f && (q_phase != 2'd0);
  assign rf_addr       = abank ? {bsr, faddr} : {{BW{!low_f}}, faddr};
  assign pc_step_valid = live && (q_phase == 2'd3);
  assign pc_step       = skip_q ? (two_q ? 2'd3 : 2'd2) : 2'd1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_phase  <= 2'd0;
      ir       <= '0;
      two_q    <= 1'b0;
      bit_q    <= 1'b0;
      skip_q   <= 1'b0;
      nop_left <= 2'd0;
    end else begin
      q_phase <= q_phase + 2'd1;
      case (q_phase)
        2'd0: if (live) begin
          ir    <= instr_word;
          two_q <= next_two_word;
        end
        2'd1: bit_q  <= rf_rdata[bsel];
        2'd2: skip_q <= live && is_tst && (bit_q == !opc[0]);
        default: begin
          if (!live)       nop_left <= nop_left - 2'd1;
          else if (skip_q) nop_left <= two_q ? 2'd2 : 2'd1;
          skip_q <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/bitskip_unit_chk.sv
module bitskip_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] q_phase,
  input logic       rf_rd_en,
  input logic       idx_mode,
  input logic       nop_cycle,
  input logic       pc_step_valid,
  input logic [1:0] pc_step
);
  assert_phase_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (q_phase == 2'd3) |=> (q_phase == 2'd0));

  assert_phase_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (q_phase != 2'd3) |=> (q_phase == $past(q_phase) + 2'd1));

  assert_read_phase_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rf_rd_en |-> (q_phase == 2'd1) && !nop_cycle);

  assert_idx_phase_R6: assert property (@(posedge clk) disable iff (!rst_n)
    idx_mode |-> (q_phase != 2'd0));

  assert_nop_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    nop_cycle |-> !rf_rd_en && !pc_step_valid && !idx_mode);

  assert_nop_stable_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (q_phase != 2'd0) |-> $stable(nop_cycle));

  assert_skip_squash_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_step_valid && pc_step != 2'd1) |=> nop_cycle);

  assert_noskip_live_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_step_valid && pc_step == 2'd1) |=> !nop_cycle);
endmodule

bind bitskip_unit bitskip_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .q_phase(q_phase), .rf_rd_en(rf_rd_en),
  .idx_mode(idx_mode), .nop_cycle(nop_cycle), .pc_step_valid(pc_step_valid),
  .pc_step(pc_step)
);

// File: tb/bitskip_unit_bench.sv
`timescale 1ns/1ps
module bitskip_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] instr_word = '0;
  logic        next_two_word = 1'b0;
  logic        ext_en = 1'b0;
  logic [3:0]  bsr = 4'h0;
  logic [7:0]  rf_rdata;
  logic [1:0]  q_phase;
  logic        rf_rd_en, idx_mode, nop_cycle, pc_step_valid;
  logic [11:0] rf_addr;
  logic [1:0]  pc_step;
  logic        flip = 1'b0;
  int          checks = 0, fails = 0;

  always #2 clk = ~clk;

  bitskip_unit u_bitskip_unit (
    .clk(clk), .rst_n(rst_n), .instr_word(instr_word), .next_two_word(next_two_word),
    .ext_en(ext_en), .bsr(bsr), .rf_rdata(rf_rdata), .q_phase(q_phase),
    .rf_rd_en(rf_rd_en), .rf_addr(rf_addr), .idx_mode(idx_mode), .nop_cycle(nop_cycle),
    .pc_step_valid(pc_step_valid), .pc_step(pc_step)
  );

  function automatic logic [7:0] mem_of(input logic [11:0] a, input logic inv);
    return (a[7:0] * 8'd29) ^ {a[11:8], a[11:8]} ^ 8'h5A ^ {8{inv}};
  endfunction

  always_comb rf_rdata = mem_of(rf_addr, flip);

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d at t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic exec(input logic [3:0] opc, input int b, input logic a, input logic [7:0] f,
                      input logic two, input string req);
    logic        tst, idx, skip, bitv;
    logic [11:0] ea;
    int          ncyc, step;
    tst  = (opc == 4'b1011) || (opc == 4'b1010);
    idx  = tst && !a && ext_en && (f < 8'h60);
    ea   = a ? {bsr, f} : ((f < 8'h60) ? {4'h0, f} : {4'hF, f});
    bitv = mem_of(ea, flip)[b];
    skip = tst && ((opc == 4'b1011) ? !bitv : bitv);
    step = skip ? (two ? 3 : 2) : 1;
    ncyc = step;
    for (int c = 0; c < ncyc; c++) begin
      for (int p = 0; p < 4; p++) begin
        if (c == 0 && p == 0) begin
          instr_word    = {opc, 3'(b), a, f};
          next_two_word = two;
        end else begin
          instr_word    = 16'hA0FF ^ 16'(c * 7 + p);
          next_two_word = ~two;
        end
        check("R2 phase", q_phase, p);
        check({req, " R12 nop_cycle"}, nop_cycle, (c != 0));
        if (p == 1) begin
          check({req, " R3/R13 rd_en"}, rf_rd_en, (c == 0) && tst);
          if (c == 0 && tst) begin
            check({req, " R4/R5 addr"}, rf_addr, ea);
            check({req, " R6 idx"}, idx_mode, idx);
          end else check("R6 idx off", idx_mode, 0);
        end
        if (p == 3) begin
          check({req, " R9 step_valid"}, pc_step_valid, (c == 0));
          if (c == 0) check({req, " R10/R11 step"}, pc_step, step);
        end else check("R9 step_valid off", pc_step_valid, 0);
        @(posedge clk);
        @(negedge clk);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 phase", q_phase, 0);
    check("R1 nop", nop_cycle, 0);
    check("R1 rd_en", rf_rd_en, 0);
    check("R1 step_valid", pc_step_valid, 0);
    check("R1 idx", idx_mode, 0);
    for (int fl = 0; fl < 2; fl++) begin
      flip = fl[0];
      for (int b = 0; b < 8; b++) begin
        for (int t = 0; t < 2; t++) begin
          bsr = 4'(b + 3);
          exec(4'b1011, b, 1'b1, 8'(b * 19 + 5), t[0], "R7 clear banked");
          exec(4'b1010, b, 1'b1, 8'(b * 23 + 9), t[0], "R8 set banked");
          exec(4'b1011, b, 1'b0, 8'(b * 11), t[0], "R7 clear access low R5");
          exec(4'b1010, b, 1'b0, 8'h60 + 8'(b * 17), t[0], "R8 set access high R5");
        end
      end
    end
    flip = 1'b0;
    ext_en = 1'b1;
    for (int b = 0; b < 8; b++) begin
      exec(4'b1010, b, 1'b0, 8'h5F - 8'(b), b[0], "R6 indexed");
      exec(4'b1011, b, 1'b0, 8'h60 + 8'(b), b[1], "R6 not indexed high");
      exec(4'b1011, b, 1'b1, 8'h10 + 8'(b), b[0], "R6 not indexed banked");
    end
    ext_en = 1'b0;
    exec(4'b0000, 0, 1'b0, 8'h00, 1'b1, "R13 other");
    exec(4'b1001, 7, 1'b1, 8'h33, 1'b0, "R13 other");
    exec(4'b1110, 3, 1'b0, 8'h70, 1'b1, "R13 other");
    exec(4'b1011, 2, 1'b0, 8'h00, 1'b1, "R11 two-word");
    exec(4'b1010, 2, 1'b0, 8'h00, 1'b1, "R11 two-word");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule